// File: doc/BRIEF.md
# Multi-Path Programmable Time-Base Divider

This block turns one fast reference clock into a slower time-base clock. A two-bit mode input picks one of four paths: off, a divide-by-two toggle, an even high-speed divider set by a 4-bit code, or a divide-by-eight prescaler that feeds a low-speed divider set by a 16-bit code. All paths are built as clock-enabled counters in the fast clock domain. The divided output always leaves a registered flop.

The block also drives three steady control lines for the surrounding clock circuitry. The first enables the PLL. The second enables the internal reference. The third selects the external reference. All three follow the mode and the reference choice. When the mode or either divider code changes, the block restarts from a clean low phase, so no runt pulse appears.

Top module: `tbase_div`

## Requirements
- R1: After reset, and whenever the mode is 00, `clk_out` is low and `pll_en`, `ref_sel` and `int_ref_en` are all low.
- R2: In mode 01 the output period is 32 + 16×N fast cycles, where N is the unsigned value of `ls_code` (0 to 65535).
- R3: In mode 10 with `hs_code` = c in 1..15 the output period is 2×(c+1) fast cycles (4 to 32).
- R4: In mode 10 an `hs_code` of 0 gives a period of 4 fast cycles, the same as code 1.
- R5: In mode 11 the output toggles on every fast edge, giving a period of 2 with either code value.
- R6: `pll_en` is high in modes 01, 10 and 11 and low in mode 00.
- R7: `use_int_ref` = 1 selects the internal reference. When `pll_en` is high, `int_ref_en` equals `use_int_ref` and `ref_sel` equals its inverse.
- R8: On the first fast edge at which `mode`, `hs_code` or `ls_code` differs from its value at the previous edge, `clk_out` goes low and all counting restarts. The next high phase comes only after a full low half-period of the new ratio.
- R9: The high and low phases of the output are each exactly half the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Path select: 00 off, 01 prescaler plus low-speed divider, 10 high-speed divider, 11 divide by two |
| hs_code | input | 4 | High-speed divider code for mode 10 |
| ls_code | input | 16 | Low-speed divider code for mode 01 |
| use_int_ref | input | 1 | 1 selects the internal reference, 0 the external one |
| clk_out | output | 1 | Divided time-base clock |
| pll_en | output | 1 | PLL enable |
| int_ref_en | output | 1 | Internal reference enable |
| ref_sel | output | 1 | Reference select, high for the external reference |

## Verification
Each path is driven at its smallest and at a large divider code. The smallest codes expose an off-by-one in a terminal count. The large codes show that the prescaler and the low-speed counter multiply rather than add.

In mode 10, codes 0 and 1 are compared with each other, which separates the clamp from a plain 2×(c+1) formula. Divider codes are changed in the middle of a high phase. This shows whether the restart forces the output low and whether the next phase has the full new length, or whether a truncated pulse leaks through.

Both reference choices are tried in every mode. This tells a swapped select line apart from an enable that fails to gate.

// File: rtl/tbase_pkg.sv
// Package: shared mode encoding for the time-base divider.
// Assumes the two-bit mode field is decoded the same way everywhere.
package tbase_pkg;
    typedef enum logic [1:0] {
        TB_OFF  = 2'b00,
        TB_LOW  = 2'b01,
        TB_HIGH = 2'b10,
        TB_FAST = 2'b11
    } tb_mode_e;
endpackage

// File: rtl/tb_ctrl_dec.sv
// Module: decodes the mode and reference choice into the three steady
// control lines. Purely combinational; assumes the inputs are synchronous
// to the fast clock.
module tb_ctrl_dec
    import tbase_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       use_int_ref,
    output logic       pll_en,
    output logic       int_ref_en,
    output logic       ref_sel
);
    // Purpose: the PLL runs in any active path; the reference lines are gated by it.
    always_comb begin
        pll_en     = (tb_mode_e'(mode) != TB_OFF);
        int_ref_en = pll_en &&  use_int_ref;
        ref_sel    = pll_en && !use_int_ref;
    end
endmodule

// File: rtl/tb_halfcnt.sv
// Module: clock-enabled wrap counter. It counts 0..last on each step and
// raises flip for the step that wraps. A synchronous clear has priority.
// Assumes last changes only together with a clear.
module tb_halfcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         flip
);
    logic [W-1:0] cnt;

    // Purpose: flag the wrapping step.
    always_comb flip = step && (cnt == last);

    // Purpose: advance or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (step)      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    // R9: with the limit steady the count never passes the half-period limit.
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= last));
    // R8: a clear always brings the count back to zero.
    assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/tbase_div.sv
// Module: top of the time-base divider. It registers the configuration to
// detect changes, picks the toggle source for the selected path and holds
// the output flop. Assumes all inputs are synchronous to clk.
module tbase_div
    import tbase_pkg::*;
#(
    parameter int HS_W    = 4,
    parameter int LS_W    = 16,
    parameter int PRE_DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [HS_W-1:0] hs_code,
    input  logic [LS_W-1:0] ls_code,
    input  logic            use_int_ref,
    output logic            clk_out,
    output logic            pll_en,
    output logic            int_ref_en,
    output logic            ref_sel
);
    localparam int HS_CW  = HS_W + 1;
    localparam int LS_CW  = LS_W + 1;
    localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    tb_mode_e        mode_e, mode_q;
    logic [HS_W-1:0] hs_q;
    logic [LS_W-1:0] ls_q;
    logic            restart;
    logic [HS_CW-1:0] hs_last;
    logic [LS_CW-1:0] ls_last;
    logic            pre_flip, hs_flip, ls_flip, toggle;
    logic            out_q;

    // Purpose: type the raw mode input.
    always_comb mode_e = tb_mode_e'(mode);

    // Purpose: flag any change of configuration since the last edge.
    always_comb restart = (mode_e != mode_q) || (hs_code != hs_q) || (ls_code != ls_q);

    // Purpose: remember the configuration seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TB_OFF;
            hs_q   <= '0;
            ls_q   <= '0;
        end else begin
            mode_q <= mode_e;
            hs_q   <= hs_code;
            ls_q   <= ls_code;
        end
    end

    // Purpose: half-period limits; code 0 of the fast divider is clamped to code 1.
    always_comb begin
        hs_last = (hs_code == '0) ? HS_CW'(1) : {1'b0, hs_code};
        ls_last = {1'b0, ls_code} + LS_CW'(1);
    end

    tb_halfcnt #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .clr(restart || mode_e != TB_LOW), .step(1'b1),
        .last(PRE_LAST), .flip(pre_flip)
    );

    tb_halfcnt #(.W(LS_CW)) u_ls (
        .clk(clk), .rst_n(rst_n),
        .clr(restart || mode_e != TB_LOW), .step(pre_flip),
        .last(ls_last), .flip(ls_flip)
    );

    tb_halfcnt #(.W(HS_CW)) u_hs (
        .clk(clk), .rst_n(rst_n),
        .clr(restart || mode_e != TB_HIGH), .step(1'b1),
        .last(hs_last), .flip(hs_flip)
    );

    // Purpose: pick the toggle source of the active path.
    always_comb begin
        unique case (mode_e)
            TB_LOW:  toggle = ls_flip;
            TB_HIGH: toggle = hs_flip;
            TB_FAST: toggle = 1'b1;
            default: toggle = 1'b0;
        endcase
    end

    // Purpose: output flop, forced low on reset, restart or off.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || mode_e == TB_OFF) out_q <= 1'b0;
        else if (toggle)                           out_q <= ~out_q;
    end

    always_comb clk_out = out_q;

    tb_ctrl_dec u_ctrl (
        .mode(mode), .use_int_ref(use_int_ref),
        .pll_en(pll_en), .int_ref_en(int_ref_en), .ref_sel(ref_sel)
    );

    assert_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == TB_OFF) |=> !clk_out);
    assert_off_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == TB_OFF) |-> (!pll_en && !ref_sel && !int_ref_en));
    assert_pll_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e != TB_OFF) |-> pll_en);
    assert_ref_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> (ref_sel != int_ref_en));
    assert_restart_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !clk_out);
    assert_fast_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == TB_FAST && !restart) |=> (clk_out != $past(clk_out)));
endmodule

// File: tb/tb_tbase_div.sv
module tb_tbase_div;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [3:0]  hs_code = '0;
    logic [15:0] ls_code = '0;
    logic        use_int_ref = 1'b0;
    logic        clk_out, pll_en, int_ref_en, ref_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference-model state.
    logic [1:0]  pm = '0;
    logic [3:0]  ph = '0;
    logic [15:0] pl = '0;
    longint      k = 0;
    logic        exp_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_div dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .hs_code(hs_code),
        .ls_code(ls_code), .use_int_ref(use_int_ref), .clk_out(clk_out),
        .pll_en(pll_en), .int_ref_en(int_ref_en), .ref_sel(ref_sel)
    );

    function automatic longint half_len(input logic [1:0] m, input logic [3:0] h,
                                        input logic [15:0] l);
        if (m == 2'b01)      return 16 + 8 * longint'(l);
        else if (m == 2'b10) return (h == 0) ? 2 : longint'(h) + 1;
        else                 return 1;
    endfunction

    // Behavioural model: cycles since the last restart decide the phase.
    always @(posedge clk) begin
        if (!rst_n) begin
            pm = '0; ph = '0; pl = '0; k = 0;
        end else if (mode != pm || hs_code != ph || ls_code != pl || mode == 2'b00) begin
            pm = mode; ph = hs_code; pl = ls_code; k = 0;
        end else begin
            k = k + 1;
        end
        exp_out = (rst_n && mode != 2'b00) ? logic'((k / half_len(mode, hs_code, ls_code)) % 2) : 1'b0;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (clk_out !== exp_out) begin
                errors++;
                $display("FAIL %s cycle compare mode=%0d: clk_out=%0b expected %0b",
                    (mode == 2'b01) ? "R2" : (mode == 2'b10) ? "R3" :
                    (mode == 2'b11) ? "R5" : "R1", mode, clk_out, exp_out);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] h,
                           input logic [15:0] l, input logic ir);
        @(negedge clk);
        mode = m; hs_code = h; ls_code = l; use_int_ref = ir;
    endtask

    task automatic check_ctrl(input string req);
        @(negedge clk);
        check(pll_en === (mode != 2'b00), req, "pll_en", pll_en, mode != 2'b00);
        check(int_ref_en === (mode != 2'b00 && use_int_ref), req, "int_ref_en",
              int_ref_en, mode != 2'b00 && use_int_ref);
        check(ref_sel === (mode != 2'b00 && !use_int_ref), req, "ref_sel",
              ref_sel, mode != 2'b00 && !use_int_ref);
    endtask

    // Measures one full high phase and the following low phase.
    task automatic measure(input longint period, input string req);
        longint hi = 0;
        longint lo = 0;
        int guard = 0;
        @(negedge clk);
        while (clk_out !== 1'b0 && guard < 200000) begin @(negedge clk); guard++; end
        while (clk_out !== 1'b1 && guard < 200000) begin @(negedge clk); guard++; end
        while (clk_out === 1'b1 && guard < 200000) begin hi++; @(negedge clk); guard++; end
        while (clk_out === 1'b0 && guard < 200000) begin lo++; @(negedge clk); guard++; end
        check(hi + lo == period, req, "period", hi + lo, period);
        check(hi == period / 2, "R9", "high phase", hi, period / 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_out === 1'b0, "R1", "clk_out after reset", clk_out, 0);
        check_ctrl("R1");

        // R1: mode 00 with nonzero codes keeps everything low.
        set_cfg(2'b00, 4'd9, 16'd3, 1'b1);
        repeat (10) @(negedge clk);
        check(clk_out === 1'b0, "R1", "clk_out in off mode", clk_out, 0);
        check_ctrl("R1");

        // R5 / R6 / R7: divide by two, both references.
        set_cfg(2'b11, 4'd0, 16'd0, 1'b0);
        check_ctrl("R7");
        measure(2, "R5");
        set_cfg(2'b11, 4'd0, 16'd0, 1'b1);
        check_ctrl("R6");
        measure(2, "R5");

        // R3 / R4: fast divider at extremes and the clamp.
        set_cfg(2'b10, 4'd1, 16'd0, 1'b0);
        check_ctrl("R7");
        measure(4, "R3");
        set_cfg(2'b10, 4'd15, 16'd0, 1'b1);
        check_ctrl("R6");
        measure(32, "R3");
        set_cfg(2'b10, 4'd0, 16'd0, 1'b1);
        measure(4, "R4");

        // R8: change the code during a high phase.
        set_cfg(2'b10, 4'd7, 16'd0, 1'b0);
        while (clk_out !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        mode = 2'b10; hs_code = 4'd3;
        @(negedge clk);
        check(clk_out === 1'b0, "R8", "clk_out after code change", clk_out, 0);
        repeat (3) @(negedge clk);
        check(clk_out === 1'b0, "R8", "low phase held", clk_out, 0);
        @(negedge clk);
        check(clk_out === 1'b1, "R8", "first high after restart", clk_out, 1);
        // R8: a change to the unused code also restarts.
        repeat (2) @(negedge clk);
        ls_code = 16'd5;
        @(negedge clk);
        check(clk_out === 1'b0, "R8", "restart on ls_code change", clk_out, 0);

        // R2: prescaled low-speed divider at min and a large code.
        set_cfg(2'b01, 4'd0, 16'd0, 1'b0);
        check_ctrl("R6");
        measure(32, "R2");
        set_cfg(2'b01, 4'd0, 16'd3000, 1'b1);
        check_ctrl("R7");
        measure(48032, "R2");

        // R1: back to off.
        set_cfg(2'b00, 4'd0, 16'd0, 1'b0);
        repeat (2) @(negedge clk);
        check(clk_out === 1'b0, "R1", "clk_out after return to off", clk_out, 0);
        check_ctrl("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule